// File: doc/BRIEF.md
# SDRAM Column Burst Engine with Clock Suspend

This block is the device-side column logic of a synchronous DRAM. It takes READ and WRITE commands with a bank and a starting column while it is idle. For each burst it steps a column offset through the aligned burst block, fetches read data from the cell array and returns it on the data bus after the CAS latency, or commits the data bus to the array on each write beat. Row activation, refresh, power-down and the programming of burst length and latency lie outside it. The burst length and latency arrive as static inputs.

The clock-enable input is registered on every rising edge. While a burst or a read return is in progress, a low sample gates the next internal edge. On a gated edge the offset counter, the latency pipeline and the output register all hold, the bus stays driven with its current value, and any command or write data on the pins is discarded. A high sample lets internal operation continue on the following edge. When the block is idle, clock enable has no effect.

Top module: `sdram_burst_core`

## Requirements
- R1: After reset `dq_oe` and `arr_re` are low, and they stay low until a READ is accepted.
- R2: `cmd` encodes 2'b01 as READ, 2'b10 as WRITE, and 2'b00 or 2'b11 as no operation. A command is accepted on any rising edge where the block is idle, whatever CKE was at the edge before. Commands that arrive while the block is busy are ignored. `arr_we` and `arr_re` are never high together.
- R3: The burst length is 1, 2, 4 or 8 for `bl_sel` 0, 1, 2 or 3. Beat i uses column base + ((s mod BL) + i) mod BL, where s is the start column and base is s rounded down to a multiple of BL.
- R4: A WRITE commits beat 0 from `dq_in` at the command edge. Each later beat comes from `dq_in` at the next non-suspended edge. Exactly BL array writes occur.
- R5: For a READ accepted at internal edge 0, beat i is on `dq_out` with `dq_oe` high after internal edge CL+i. CL is 2 when `cl3` is 0 and 3 when `cl3` is 1.
- R6: `dq_oe` falls after internal edge CL+BL, one internal cycle after the last beat. It rises and falls only on internal edges.
- R7: Suppose CKE is sampled low at a rising edge while the block is busy (a burst in progress or read data pending). Then the next rising edge is suspended: `dq_out`, `dq_oe` and the beat counter keep their values.
- R8: On a suspended edge, `cmd`, the address and `dq_in` are ignored, and nothing is written to the array.
- R9: A high CKE sample lets the next rising edge act as a normal internal edge. A burst with suspended edges produces the same beat sequence as one with none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable, registered each rising edge |
| cmd | input | 2 | Command: 01 READ, 10 WRITE, others no operation |
| bank | input | BANK_W | Bank of the command |
| col | input | COL_W | Start column of the command |
| bl_sel | input | 2 | Burst length select (1, 2, 4, 8) |
| cl3 | input | 1 | CAS latency 3 when high, 2 when low |
| dq_in | input | DW | Write data from the bus |
| dq_out | output | DW | Read data driven onto the bus |
| dq_oe | output | 1 | Data bus output enable |
| arr_we | output | 1 | Array write strobe for this edge |
| arr_re | output | 1 | Array read request |
| arr_bank | output | BANK_W | Array bank address |
| arr_col | output | COL_W | Array column address |
| arr_wdata | output | DW | Array write data |
| arr_rdata | input | DW | Array read data, combinational from the address |

## Verification
A beat counter that advances on a gated edge shows at the ports as a skipped column. On a read, that is a wrong word on `dq_out` one latency later. On a write, the array contents are shifted, which the readback of the same block shows. A latency pipeline that advances while frozen makes `dq_oe` rise or fall one cycle early, and the per-cycle comparison catches this in the cycle it happens. Randomly placed CKE-low windows during both burst kinds compare every cycle with a model that counts only unsuspended edges, so a leak of a discarded command or data word shows up as an extra array write or a corrupted readback within the same burst.

// File: rtl/sdram_burst_core.sv
module sdram_burst_core #(
  parameter int DW     = 16,
  parameter int BANK_W = 2,
  parameter int COL_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke,
  input  logic [1:0]        cmd,
  input  logic [BANK_W-1:0] bank,
  input  logic [COL_W-1:0]  col,
  input  logic [1:0]        bl_sel,
  input  logic              cl3,
  input  logic [DW-1:0]     dq_in,
  output logic [DW-1:0]     dq_out,
  output logic              dq_oe,
  output logic              arr_we,
  output logic              arr_re,
  output logic [BANK_W-1:0] arr_bank,
  output logic [COL_W-1:0]  arr_col,
  output logic [DW-1:0]     arr_wdata,
  input  logic [DW-1:0]     arr_rdata
);
  localparam logic [1:0] CMD_RD = 2'b01;
  localparam logic [1:0] CMD_WR = 2'b10;

  logic              cke_q, act, is_wr, v1, v2, oe_r;
  logic [2:0]        cnt, last, blm1;
  logic [COL_W-1:0]  base, mask;
  logic [BANK_W-1:0] bank_r;
  logic [DW-1:0]     d1, d2, dout;
  logic              busy, tick, start_rd, start_wr;

  assign blm1     = (3'd1 << bl_sel) - 3'd1;
  assign busy     = act | v1 | v2 | oe_r;
  assign tick     = cke_q | ~busy;
  assign start_rd = tick & ~busy & (cmd == CMD_RD);
  assign start_wr = tick & ~busy & (cmd == CMD_WR);
  assign mask     = COL_W'(last);

  assign arr_bank  = act ? bank_r : bank;
  assign arr_col   = act ? ((base & ~mask) | ((base + COL_W'(cnt)) & mask)) : col;
  assign arr_we    = start_wr | (tick & act & is_wr);
  assign arr_re    = act & ~is_wr;
  assign arr_wdata = dq_in;
  assign dq_out    = dout;
  assign dq_oe     = oe_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cke_q  <= 1'b1;
      act    <= 1'b0;
      is_wr  <= 1'b0;
      cnt    <= '0;
      last   <= '0;
      base   <= '0;
      bank_r <= '0;
      v1     <= 1'b0;
      v2     <= 1'b0;
      oe_r   <= 1'b0;
      d1     <= '0;
      d2     <= '0;
      dout   <= '0;
    end else begin
      cke_q <= cke;
      if (tick) begin
        if (start_rd | start_wr) begin
          base   <= col;
          bank_r <= bank;
          last   <= blm1;
          is_wr  <= start_wr;
          cnt    <= start_wr ? 3'd1 : 3'd0;
          act    <= start_rd | (blm1 != 3'd0);
        end else if (act) begin
          cnt <= cnt + 3'd1;
          if (cnt == last) act <= 1'b0;
        end
        v1 <= act & ~is_wr;
        d1 <= arr_rdata;
        v2 <= v1 & cl3;
        d2 <= d1;
        oe_r <= cl3 ? v2 : v1;
        dout <= cl3 ? d2 : d1;
      end
    end
  end
endmodule

module sdram_burst_core_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic [DW-1:0] dq_out,
  input logic          dq_oe,
  input logic          arr_we,
  input logic          arr_re
);
  // R1
  quiet_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!dq_oe && !arr_re));

  // R2
  port_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(arr_we && arr_re));

  // R7
  frozen_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(dq_out) && $stable(dq_oe)));

  // R6
  oe_rise_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_oe) |-> $past(tick));

  // R6
  oe_fall_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dq_oe) |-> $past(tick));
endmodule

bind sdram_burst_core sdram_burst_core_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .tick(tick), .dq_out(dq_out),
  .dq_oe(dq_oe), .arr_we(arr_we), .arr_re(arr_re)
);

// File: tb/sdram_burst_core_tb_top.sv
module sdram_burst_core_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16, BANK_W = 2, COL_W = 9;
  localparam int DEPTH = 1 << (BANK_W + COL_W);

  logic clk = 1'b0, rst_n = 1'b0, cke = 1'b1, cl3 = 1'b0;
  logic [1:0] cmd = 2'b00, bl_sel = 2'b00;
  logic [BANK_W-1:0] bank = '0;
  logic [COL_W-1:0] col = '0;
  logic [DW-1:0] dq_in = '0, dq_out, arr_wdata, arr_rdata;
  logic dq_oe, arr_we, arr_re;
  logic [BANK_W-1:0] arr_bank;
  logic [COL_W-1:0] arr_col;
  logic [DW-1:0] mem [DEPTH];
  int total = 0, bad = 0, wcount = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_burst_core #(.DW(DW), .BANK_W(BANK_W), .COL_W(COL_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cmd(cmd), .bank(bank), .col(col),
    .bl_sel(bl_sel), .cl3(cl3), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
    .arr_we(arr_we), .arr_re(arr_re), .arr_bank(arr_bank), .arr_col(arr_col),
    .arr_wdata(arr_wdata), .arr_rdata(arr_rdata));

  assign arr_rdata = mem[{arr_bank, arr_col}];
  always @(posedge clk) if (arr_we) begin
    mem[{arr_bank, arr_col}] <= arr_wdata;
    wcount <= wcount + 1;
  end

  function automatic int seq_col(int s, int bl, int i);
    int b = s - (s % bl);
    return b + ((s % bl) + i) % bl;
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic garbage(int pct);
    cmd   = 2'($urandom);
    bank  = BANK_W'($urandom);
    col   = COL_W'($urandom);
    dq_in = DW'($urandom);
    cke   = (($urandom % 100) >= pct);
  endtask

  task automatic do_write(int bk, int c, int bls, int pct, bit pre_low);
    int bl = 1 << bls;
    logic [DW-1:0] exp [8];
    int n, w0;
    bit ck_prev;
    @(negedge clk);
    cmd = 2'b00; bl_sel = 2'(bls); cke = !pre_low;
    @(negedge clk);
    w0 = wcount;
    cmd = 2'b10; bank = BANK_W'(bk); col = COL_W'(c);
    dq_in = DW'($urandom); cke = (($urandom % 100) >= pct);
    exp[0] = dq_in;
    @(posedge clk); ck_prev = cke; n = 1;
    while (n < bl) begin
      @(negedge clk);
      garbage(pct);
      if (ck_prev) begin exp[n] = dq_in; n++; end
      @(posedge clk); ck_prev = cke;
    end
    @(negedge clk); cmd = 2'b00; cke = 1'b1;
    repeat (2) @(negedge clk);
    // R4: exactly BL array writes; R8: no writes on suspended edges
    chk(wcount - w0 == bl, "R4/R8 write count", wcount - w0, bl);
    for (int i = 0; i < bl; i++) begin
      int a = (bk << COL_W) + seq_col(c, bl, i);
      // R3 column order, R4 beat data, R9 resume
      chk(mem[a] == exp[i], "R3/R4/R9 write beat", mem[a], exp[i]);
    end
  endtask

  task automatic do_read(int bk, int c, int bls, bit l3, int pct, bit pre_low);
    int bl = 1 << bls;
    int cl = l3 ? 3 : 2;
    logic [DW-1:0] exp [8];
    int n;
    bit ck_prev, eoe;
    for (int i = 0; i < bl; i++) exp[i] = mem[(bk << COL_W) + seq_col(c, bl, i)];
    @(negedge clk);
    cmd = 2'b00; bl_sel = 2'(bls); cl3 = l3; cke = !pre_low;
    @(negedge clk);
    cmd = 2'b01; bank = BANK_W'(bk); col = COL_W'(c);
    cke = (($urandom % 100) >= pct);
    @(posedge clk); ck_prev = cke; n = 0;
    while (n < cl + bl) begin
      @(negedge clk);
      eoe = (n >= cl) && (n <= cl + bl - 1);
      // R5 latency, R7 hold while frozen
      chk(dq_oe == eoe, "R5/R7 dq_oe", dq_oe, eoe);
      if (eoe) chk(dq_out == exp[n - cl], "R3/R5/R7 read beat", dq_out, exp[n - cl]);
      garbage(pct);
      @(posedge clk);
      if (ck_prev) n++;
      ck_prev = cke;
    end
    @(negedge clk);
    // R6 release after last beat
    chk(dq_oe == 1'b0, "R6 oe release", dq_oe, 0);
    cmd = 2'b00; cke = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = DW'(i * 40503) ^ DW'(16'h5a5a);
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(dq_oe == 1'b0, "R1 dq_oe after reset", dq_oe, 0);
    chk(arr_re == 1'b0, "R1 arr_re after reset", arr_re, 0);
    chk(arr_we == 1'b0, "R1 arr_we after reset", arr_we, 0);
    // directed corners: no suspend, wrap, single beat, idle CKE low (R2)
    do_write(1, 5, 3, 0, 0);
    do_read(1, 5, 3, 0, 0, 0);
    do_read(1, 5, 3, 1, 0, 0);
    do_write(2, 511, 2, 0, 1);
    do_read(2, 511, 2, 1, 0, 1);
    do_write(3, 100, 0, 0, 1);
    do_read(3, 100, 0, 0, 60, 1);
    do_write(0, 7, 1, 80, 0);
    do_read(0, 7, 1, 1, 80, 0);
    // random bursts with CKE-low windows (R7, R8, R9)
    for (int k = 0; k < 60; k++) begin
      int bk = int'($urandom % 4), c = int'($urandom % 512), bls = int'($urandom % 4);
      int pct = int'($urandom % 60);
      do_write(bk, c, bls, pct, bit'($urandom));
      do_read(bk, c, bls, bit'($urandom), pct, bit'($urandom));
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0h expected=%0h", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule